// File: doc/BRIEF.md
# Standby Power-Mode Controller

This block puts a small processor core into one of two low-power standby states and brings it back out. The core raises a one-cycle light-standby request or a one-cycle deep-standby request when it executes the matching instruction. In light standby only the CPU clock is gated, and the main oscillator keeps running. In deep standby the main oscillator is switched off as well. A level interrupt request ends either state. Light standby resumes on the next cycle. Deep standby first turns the oscillator back on and waits a programmable number of reference-clock cycles so that it can settle.

The whole controller runs on a free-running reference clock that does not depend on the main oscillator. Deep standby is allowed only while the core runs from the main clock. When the subsystem clock is selected, a deep request is refused, the core keeps running, and an error flag pulses for one cycle. While the core is in standby, a hold output freezes register, flag and port-latch updates. A one-cycle wake acknowledge marks the first running cycle after any standby exit.

Top module: `standby_ctrl`

## Requirements
- R1: After reset, stateOut is 0 (RUN), cpuClkEn and mainOscEn are 1, and holdOut, stopErr and wakeAck are 0.
- R2: In RUN, a haltReq sampled at a clock edge moves the block to HALT (stateOut 1) on that edge: cpuClkEn 0, mainOscEn 1, holdOut 1. This happens with either value of subClkSel.
- R3: In RUN, a stopReq with subClkSel 0 moves the block to STOP (stateOut 2): cpuClkEn 0, mainOscEn 0, holdOut 1. The oscillator stays off until an interrupt arrives.
- R4: In RUN, a stopReq with subClkSel 1 is refused and stopErr is 1 for exactly the next cycle. The block stays in RUN unless haltReq is also high, in which case it enters HALT.
- R5: In HALT, irqReq high at an edge returns the block to RUN (cpuClkEn 1, holdOut 0) on that edge.
- R6: In STOP, irqReq high at an edge moves the block to WAIT_STAB (stateOut 3) with mainOscEn 1 and cpuClkEn 0. The stabCount value present at that edge is captured. WAIT_STAB lasts exactly stabCount+1 cycles, and then the block is in RUN.
- R7: Changes on irqReq during WAIT_STAB neither shorten nor lengthen the wait. Later changes to stabCount have no effect either.
- R8: haltReq and stopReq are ignored in HALT, STOP and WAIT_STAB.
- R9: wakeAck is 1 for exactly the first RUN cycle after leaving HALT or WAIT_STAB.
- R10: In RUN with subClkSel 0, if haltReq and stopReq are both high, STOP wins.
- R11: irqReq has no effect while in RUN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| rstN | input | 1 | Asynchronous active-low reset |
| haltReq | input | 1 | One-cycle light-standby request |
| stopReq | input | 1 | One-cycle deep-standby request |
| irqReq | input | 1 | Level interrupt request (wake source) |
| subClkSel | input | 1 | 1 = core runs from the subsystem clock |
| stabCount | input | 8 | Stabilization wait length (cycles minus one) |
| cpuClkEn | output | 1 | Enable for the CPU clock gate |
| mainOscEn | output | 1 | Main oscillator enable |
| holdOut | output | 1 | Freezes register, flag and port-latch updates |
| stateOut | output | 2 | 0 RUN, 1 HALT, 2 STOP, 3 WAIT_STAB |
| stopErr | output | 1 | One-cycle pulse on a refused deep request |
| wakeAck | output | 1 | One-cycle pulse in the first RUN cycle after standby |

## Verification
The state and the outputs decoded from it change on the same edge that samples a request or an interrupt. stopErr and wakeAck are registered, so they appear in the cycle that follows the causing edge. The bench changes inputs 1 ns after a rising edge and checks every result 1 ns after the edge on which it is due. For the stabilization wait it checks WAIT_STAB after each of the first stabCount edges following entry, and RUN after the next one, so an early or a late exit is caught at its exact cycle.

// File: rtl/standby_pkg.sv
package standby_pkg;
  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_HALT = 2'd1,
    ST_STOP = 2'd2,
    ST_WAIT = 2'd3
  } pwrState_t;

  // strobes from the control to the datapath
  typedef struct packed {
    logic loadCnt;
    logic decCnt;
    logic errPulse;
    logic wakePulse;
  } dpCtrl_t;
endpackage

// File: rtl/standby_fsm.sv
module standby_fsm
  import standby_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      haltReq,
  input  logic      stopReq,
  input  logic      irqReq,
  input  logic      subClkSel,
  input  logic      cntZero,
  output pwrState_t state,
  output dpCtrl_t   ctrl
);
  pwrState_t stateNxt;

  always_comb begin
    stateNxt = state;
    ctrl     = '0;
    case (state)
      ST_RUN: begin
        if (stopReq && !subClkSel) begin
          stateNxt = ST_STOP;
        end else begin
          if (stopReq) ctrl.errPulse = 1'b1;
          if (haltReq) stateNxt = ST_HALT;
        end
      end
      ST_HALT: begin
        if (irqReq) begin
          stateNxt       = ST_RUN;
          ctrl.wakePulse = 1'b1;
        end
      end
      ST_STOP: begin
        if (irqReq) begin
          stateNxt     = ST_WAIT;
          ctrl.loadCnt = 1'b1;
        end
      end
      ST_WAIT: begin
        if (cntZero) begin
          stateNxt       = ST_RUN;
          ctrl.wakePulse = 1'b1;
        end else begin
          ctrl.decCnt = 1'b1;
        end
      end
      default: stateNxt = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_RUN;
    else       state <= stateNxt;
  end

  // R2
  halt_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && haltReq && !stopReq) |=> state == ST_HALT);
  // R3
  stop_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && stopReq && !subClkSel) |=> state == ST_STOP);
  // R4
  stop_deny_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && stopReq && subClkSel && !haltReq) |=> state == ST_RUN);
  // R5
  halt_exit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HALT && irqReq) |=> state == ST_RUN);
  // R7
  wait_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WAIT && !cntZero) |=> state == ST_WAIT);
  // R11
  run_irq_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_RUN && !haltReq && !stopReq) |=> state == ST_RUN);
endmodule

// File: rtl/standby_dp.sv
module standby_dp
  import standby_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCtrl_t          ctrl,
  input  logic [CNT_W-1:0] stabCount,
  output logic             cntZero,
  output logic             stopErr,
  output logic             wakeAck
);
  logic [CNT_W-1:0] cntQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ    <= '0;
      stopErr <= 1'b0;
      wakeAck <= 1'b0;
    end else begin
      if (ctrl.loadCnt)      cntQ <= stabCount;
      else if (ctrl.decCnt)  cntQ <= cntQ - 1'b1;
      stopErr <= ctrl.errPulse;
      wakeAck <= ctrl.wakePulse;
    end
  end

  assign cntZero = (cntQ == '0);

  // R6
  load_cnt_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.loadCnt |=> cntQ == $past(stabCount));
  // R4
  err_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.errPulse |=> stopErr);
  // R9
  wake_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.wakePulse |=> wakeAck);
endmodule

// File: rtl/standby_ctrl.sv
module standby_ctrl
  import standby_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             haltReq,
  input  logic             stopReq,
  input  logic             irqReq,
  input  logic             subClkSel,
  input  logic [CNT_W-1:0] stabCount,
  output logic             cpuClkEn,
  output logic             mainOscEn,
  output logic             holdOut,
  output logic [1:0]       stateOut,
  output logic             stopErr,
  output logic             wakeAck
);
  pwrState_t state;
  dpCtrl_t   ctrl;
  logic      cntZero;

  standby_fsm u_fsm (
    .clk(clk), .rstN(rstN), .haltReq(haltReq), .stopReq(stopReq),
    .irqReq(irqReq), .subClkSel(subClkSel), .cntZero(cntZero),
    .state(state), .ctrl(ctrl)
  );

  standby_dp #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .stabCount(stabCount),
    .cntZero(cntZero), .stopErr(stopErr), .wakeAck(wakeAck)
  );

  assign stateOut  = state;
  assign cpuClkEn  = (state == ST_RUN);
  assign mainOscEn = (state != ST_STOP);
  assign holdOut   = (state != ST_RUN);

  // R3
  osc_stays_off_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stateOut == 2'd2 && !irqReq) |=> !mainOscEn);
  // R8
  req_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stateOut == 2'd1 && !irqReq) |=> stateOut == 2'd1);
endmodule

// File: tb/standby_ctrl_bench.sv
module standby_ctrl_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic haltReq = 1'b0, stopReq = 1'b0, irqReq = 1'b0, subClkSel = 1'b0;
  logic [7:0] stabCount = 8'd0;
  logic cpuClkEn, mainOscEn, holdOut, stopErr, wakeAck;
  logic [1:0] stateOut;
  int tests = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  standby_ctrl u_standby_ctrl (
    .clk(clk), .rstN(rstN), .haltReq(haltReq), .stopReq(stopReq),
    .irqReq(irqReq), .subClkSel(subClkSel), .stabCount(stabCount),
    .cpuClkEn(cpuClkEn), .mainOscEn(mainOscEn), .holdOut(holdOut),
    .stateOut(stateOut), .stopErr(stopErr), .wakeAck(wakeAck)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // state plus the three decoded outputs
  task automatic checkOuts(input string req, input int st, input int cpu,
                           input int osc, input int hold);
    check({req, " state"}, int'(stateOut), st);
    check({req, " cpuClkEn"}, int'(cpuClkEn), cpu);
    check({req, " mainOscEn"}, int'(mainOscEn), osc);
    check({req, " holdOut"}, int'(holdOut), hold);
  endtask

  task automatic t_reset();
    checkOuts("R1 reset", 0, 1, 1, 0);
    check("R1 stopErr", int'(stopErr), 0);
    check("R1 wakeAck", int'(wakeAck), 0);
  endtask

  task automatic t_halt();
    haltReq = 1; tick(); haltReq = 0;
    checkOuts("R2 halt", 1, 0, 1, 1);
    stopReq = 1; tick(); stopReq = 0;
    check("R8 stop in halt", int'(stateOut), 1);
    irqReq = 1; tick(); irqReq = 0;
    checkOuts("R5 halt exit", 0, 1, 1, 0);
    check("R9 wakeAck halt", int'(wakeAck), 1);
    tick();
    check("R9 wakeAck one cycle", int'(wakeAck), 0);
  endtask

  task automatic t_stop();
    stabCount = 8'd3;
    stopReq = 1; tick(); stopReq = 0;
    checkOuts("R3 stop", 2, 0, 0, 1);
    haltReq = 1; tick(); haltReq = 0;
    checkOuts("R8 halt in stop", 2, 0, 0, 1);
    irqReq = 1; tick(); irqReq = 0;
    checkOuts("R6 wait entry", 3, 0, 1, 1);
    stabCount = 8'd0;
    for (int k = 0; k < 3; k++) begin
      irqReq = (k % 2 == 0);
      stopReq = (k == 1);
      tick();
      stopReq = 0;
      check("R7 still waiting", int'(stateOut), 3);
    end
    irqReq = 0;
    tick();
    checkOuts("R6 wait done", 0, 1, 1, 0);
    check("R9 wakeAck stop", int'(wakeAck), 1);
    tick();
    check("R9 wakeAck clear", int'(wakeAck), 0);
  endtask

  task automatic t_stab_zero();
    stabCount = 8'd0;
    stopReq = 1; tick(); stopReq = 0;
    irqReq = 1; tick(); irqReq = 0;
    check("R6 zero wait entry", int'(stateOut), 3);
    tick();
    check("R6 zero wait exit", int'(stateOut), 0);
  endtask

  task automatic t_stop_denied();
    subClkSel = 1;
    stopReq = 1; tick(); stopReq = 0;
    checkOuts("R4 denied", 0, 1, 1, 0);
    check("R4 stopErr", int'(stopErr), 1);
    tick();
    check("R4 stopErr one cycle", int'(stopErr), 0);
    haltReq = 1; stopReq = 1; tick(); haltReq = 0; stopReq = 0;
    checkOuts("R4 denied plus halt", 1, 0, 1, 1);
    check("R4 stopErr with halt", int'(stopErr), 1);
    irqReq = 1; tick(); irqReq = 0;
    check("R5 exit on sub clock", int'(stateOut), 0);
    subClkSel = 0;
  endtask

  task automatic t_priority();
    stabCount = 8'd1;
    haltReq = 1; stopReq = 1; tick(); haltReq = 0; stopReq = 0;
    checkOuts("R10 stop wins", 2, 0, 0, 1);
    check("R10 no error", int'(stopErr), 0);
    irqReq = 1; tick(); irqReq = 0;
    tick();
    check("R6 two cycle wait", int'(stateOut), 3);
    tick();
    check("R6 two cycle exit", int'(stateOut), 0);
  endtask

  task automatic t_irq_run();
    irqReq = 1;
    for (int k = 0; k < 3; k++) begin
      tick();
      checkOuts("R11 irq in run", 0, 1, 1, 0);
      check("R11 no wakeAck", int'(wakeAck), 0);
    end
    irqReq = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #12 rstN = 1;
    tick();
    t_reset();
    t_halt();
    t_stop();
    t_stab_zero();
    t_stop_denied();
    t_priority();
    t_irq_run();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule